// File: doc/BRIEF.md
# Banked Control Register File

This block holds the processor control state that sits beside the general register file: a status word with a live byte and a backup byte, a separate condition flag, two stack pointer save slots, two backup program counters, a backup-backup status byte and a small number of plain storage registers. Software reaches all of it through one index-addressed port. The write is synchronous and the read is combinational. A byte-wide side port gives the pipeline direct access to the live status byte and the condition flag.

The stack pointer is banked. General register 15 always holds the pointer that belongs to the current stack mode, which is bit 7 of the live status byte. The other pointer is kept in a save slot inside this block. Accesses to the interrupt or user stack pointer index are redirected either to register 15 or to the save slot, depending on the mode. A status-word write that flips the mode bit exchanges register 15 with the right slot in one cycle. The block reaches register 15 through a dedicated port: it reads the current value and drives a write enable and write data.

Top module: `banked_cr_file`

## Requirements
- R1: After a synchronous active-low reset, every index reads zero and the status byte port reads zero.
- R2: Reading index 0 (status word) returns the backup status byte ANDed with 0xC1 in bits 15..8, live status bits 7..6 in bits 7..6 and the condition flag in bit 0. All other bits read as zero.
- R3: Writing index 0 loads data bits 15..8 into the backup status byte and bits 7..0 into the live status byte, and sets the condition flag from bit 0.
- R4: A write to index 0 that changes the mode bit (live status bit 7) from 0 to 1 stores register 15 into the interrupt slot and loads register 15 from the user slot. A change from 1 to 0 stores register 15 into the user slot and loads it from the interrupt slot. A write that leaves the mode bit unchanged does not touch register 15.
- R5: Index 2 (interrupt stack pointer) reads and writes register 15 while the mode bit is 0, and its own slot while it is 1. Index 3 (user stack pointer) does the opposite.
- R6: Index 1 (condition) reads the condition flag in bit 0 and zero elsewhere. A write to it changes only the flag, taken from data bit 0.
- R7: Index 6 (backup PC) and index 14 (second backup PC) store all 32 bits, but always read with bit 0 forced to zero.
- R8: Index 8 (second backup status) stores data bits 7..0 and reads them ANDed with 0xC1.
- R9: Indices 4 and 5 are plain 32-bit storage that reads back exactly what was written.
- R10: Any other index reads zero, and a write to it changes no state.
- R11: The status byte port reads the live status byte with bit 0 replaced by the condition flag. A write through it sets the live byte and the flag together and never swaps the stack pointer.
- R12: When the index port writes index 0 or index 1 in the same cycle as a status byte port write, the index port write takes effect and the status byte port write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cr_wr_en | input | 1 | Index port write enable |
| cr_wr_idx | input | 4 | Index port write index |
| cr_wr_data | input | 32 | Index port write data |
| cr_rd_idx | input | 4 | Index port read index |
| cr_rd_data | output | 32 | Index port read data (combinational) |
| st_wr_en | input | 1 | Status byte port write enable |
| st_wr_data | input | 8 | Status byte port write data |
| st_rd_data | output | 8 | Status byte port read data |
| sp_q | input | 32 | Current value of general register 15 |
| sp_we | output | 1 | Write enable for general register 15 |
| sp_d | output | 32 | Write data for general register 15 |

## Verification
The bench builds the block with its defaults: 32-bit data, a 4-bit index and two spare registers starting at index 4. This covers every named index, both spare slots and the unmapped indices 7 and 15. The bench models general register 15 as a plain register behind the dedicated port, so mode swaps in both directions, redirected stack accesses and the non-swapping byte port write all show up as register values. A reset before each scenario keeps the expected values independent from one scenario to the next.

// File: rtl/cr_pkg.sv
// Package: shared index map, masks and the write-select bundle of the
// banked control register file. Assumes a 4-bit index space.
package cr_pkg;
    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] IDX_STATUS  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_COND    = 4'd1;
    localparam logic [IDX_W-1:0] IDX_SP_INT  = 4'd2;
    localparam logic [IDX_W-1:0] IDX_SP_USR  = 4'd3;
    localparam logic [IDX_W-1:0] IDX_BKPC    = 4'd6;
    localparam logic [IDX_W-1:0] IDX_BKBKST  = 4'd8;
    localparam logic [IDX_W-1:0] IDX_BKBKPC  = 4'd14;

    localparam logic [7:0] BK_ST_MASK   = 8'hC1;
    localparam logic [7:0] LIVE_ST_MASK = 8'hC0;
    localparam int         MODE_BIT     = 7;

    // One-hot write selects for the named registers
    typedef struct packed {
        logic status;
        logic cond;
        logic sp_int;
        logic sp_usr;
        logic bkpc;
        logic bkbkst;
        logic bkbkpc;
    } wr_sel_t;
endpackage

// File: rtl/cr_wr_decode.sv
// Write decoder: turns the write enable and index into one-hot selects
// for the named registers and the spare storage slots.
// Assumes the spare index range does not overlap a named index.
module cr_wr_decode
    import cr_pkg::*;
#(
    parameter int SPARE_BASE = 4,
    parameter int NUM_SPARE  = 2
) (
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    output wr_sel_t              sel,
    output logic [NUM_SPARE-1:0] spare_sel
);
    // Named register selects
    always_comb begin
        sel        = '0;
        sel.status = wr_en && (wr_idx == IDX_STATUS);
        sel.cond   = wr_en && (wr_idx == IDX_COND);
        sel.sp_int = wr_en && (wr_idx == IDX_SP_INT);
        sel.sp_usr = wr_en && (wr_idx == IDX_SP_USR);
        sel.bkpc   = wr_en && (wr_idx == IDX_BKPC);
        sel.bkbkst = wr_en && (wr_idx == IDX_BKBKST);
        sel.bkbkpc = wr_en && (wr_idx == IDX_BKBKPC);
    end

    // Spare slot selects, one per slot
    for (genvar k = 0; k < NUM_SPARE; k++) begin : g_spare_sel
        localparam logic [IDX_W-1:0] SLOT_IDX = IDX_W'(SPARE_BASE + k);
        assign spare_sel[k] = wr_en && (wr_idx == SLOT_IDX);
    end
endmodule

// File: rtl/cr_status_regs.sv
// Status state: live status byte, backup status byte, second backup
// status byte and the condition flag. The index port has priority over
// the status byte port when both write the status or the condition.
module cr_status_regs
    import cr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_sel_t           sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              st_wr_en,
    input  logic [7:0]        st_wr_data,
    output logic [7:0]        live_st,
    output logic [7:0]        bk_st,
    output logic [7:0]        bkbk_st,
    output logic              cond,
    output logic              mode
);
    logic idx_owns;
    assign idx_owns = sel.status || sel.cond;
    assign mode     = live_st[MODE_BIT];

    // Live byte, backup byte and condition flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_st <= '0;
            bk_st   <= '0;
            cond    <= 1'b0;
        end else if (sel.status) begin
            live_st <= wr_data[7:0];
            bk_st   <= wr_data[15:8];
            cond    <= wr_data[0];
        end else if (sel.cond) begin
            cond    <= wr_data[0];
        end else if (st_wr_en && !idx_owns) begin
            live_st <= st_wr_data;
            cond    <= st_wr_data[0];
        end
    end

    // Second backup status byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            bkbk_st <= '0;
        else if (sel.bkbkst)
            bkbk_st <= wr_data[7:0];
    end
endmodule

// File: rtl/cr_stack_bank.sv
// Stack pointer bank: keeps the inactive pointer in a save slot, redirects
// stack index accesses by mode, and swaps register 15 with the correct slot
// when a status write flips the mode bit. Assumes register 15 lives outside.
module cr_stack_bank
    import cr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  wr_sel_t           sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] sp_q,
    output logic [DATA_W-1:0] int_slot,
    output logic [DATA_W-1:0] usr_slot,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_d
);
    logic swap;
    assign swap = sel.status && (wr_data[MODE_BIT] != mode);

    // Register 15 write port: swap reload or redirected pointer write
    always_comb begin
        sp_we = 1'b0;
        sp_d  = wr_data;
        if (swap) begin
            sp_we = 1'b1;
            sp_d  = mode ? int_slot : usr_slot;
        end else if (sel.sp_int && !mode) begin
            sp_we = 1'b1;
        end else if (sel.sp_usr && mode) begin
            sp_we = 1'b1;
        end
    end

    // Interrupt save slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_slot <= '0;
        else if (swap && !mode)
            int_slot <= sp_q;
        else if (sel.sp_int && mode)
            int_slot <= wr_data;
    end

    // User save slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            usr_slot <= '0;
        else if (swap && mode)
            usr_slot <= sp_q;
        else if (sel.sp_usr && !mode)
            usr_slot <= wr_data;
    end
endmodule

// File: rtl/cr_read_mux.sv
// Read formatter: selects and formats the value for the read index.
// Unmapped indices return zero. Purely combinational.
module cr_read_mux
    import cr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SPARE_BASE = 4,
    parameter int NUM_SPARE  = 2
) (
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              mode,
    input  logic [7:0]        live_st,
    input  logic [7:0]        bk_st,
    input  logic [7:0]        bkbk_st,
    input  logic              cond,
    input  logic [DATA_W-1:0] sp_q,
    input  logic [DATA_W-1:0] int_slot,
    input  logic [DATA_W-1:0] usr_slot,
    input  logic [DATA_W-1:0] bkpc,
    input  logic [DATA_W-1:0] bkbkpc,
    input  logic [DATA_W-1:0] spare [NUM_SPARE],
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] PC_MASK = ~DATA_W'(1);

    logic [DATA_W-1:0] named_val;
    logic [DATA_W-1:0] spare_val;

    // Named register formatting
    always_comb begin
        named_val = '0;
        case (rd_idx)
            IDX_STATUS: begin
                named_val[15:8] = bk_st & BK_ST_MASK;
                named_val[7:0]  = live_st & LIVE_ST_MASK;
                named_val[0]    = cond;
            end
            IDX_COND:   named_val[0] = cond;
            IDX_SP_INT: named_val = mode ? int_slot : sp_q;
            IDX_SP_USR: named_val = mode ? sp_q : usr_slot;
            IDX_BKPC:   named_val = bkpc & PC_MASK;
            IDX_BKBKST: named_val[7:0] = bkbk_st & BK_ST_MASK;
            IDX_BKBKPC: named_val = bkbkpc & PC_MASK;
            default:    named_val = '0;
        endcase
    end

    // Spare slot selection
    always_comb begin
        spare_val = '0;
        for (int k = 0; k < NUM_SPARE; k++) begin
            if (rd_idx == IDX_W'(SPARE_BASE + k))
                spare_val = spare[k];
        end
    end

    assign rd_data = named_val | spare_val;
endmodule

// File: rtl/banked_cr_file.sv
// Top: banked control register file. Index-addressed synchronous write and
// combinational read, a byte-wide status port, and a dedicated port to
// general register 15 for stack pointer banking.
module banked_cr_file
    import cr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int SPARE_BASE = 4,
    parameter int NUM_SPARE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_wr_en,
    input  logic [3:0]        cr_wr_idx,
    input  logic [31:0]       cr_wr_data,
    input  logic [3:0]        cr_rd_idx,
    output logic [31:0]       cr_rd_data,
    input  logic              st_wr_en,
    input  logic [7:0]        st_wr_data,
    output logic [7:0]        st_rd_data,
    input  logic [31:0]       sp_q,
    output logic              sp_we,
    output logic [31:0]       sp_d
);
    wr_sel_t              sel;
    logic [NUM_SPARE-1:0] spare_sel;
    logic [7:0]           live_st;
    logic [7:0]           bk_st;
    logic [7:0]           bkbk_st;
    logic                 cond;
    logic                 mode;
    logic [DATA_W-1:0]    int_slot;
    logic [DATA_W-1:0]    usr_slot;
    logic [DATA_W-1:0]    bkpc;
    logic [DATA_W-1:0]    bkbkpc;
    logic [DATA_W-1:0]    spare [NUM_SPARE];

    cr_wr_decode #(
        .SPARE_BASE(SPARE_BASE),
        .NUM_SPARE (NUM_SPARE)
    ) u_dec (
        .wr_en    (cr_wr_en),
        .wr_idx   (cr_wr_idx),
        .sel      (sel),
        .spare_sel(spare_sel)
    );

    cr_status_regs #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_data   (cr_wr_data),
        .st_wr_en  (st_wr_en),
        .st_wr_data(st_wr_data),
        .live_st   (live_st),
        .bk_st     (bk_st),
        .bkbk_st   (bkbk_st),
        .cond      (cond),
        .mode      (mode)
    );

    cr_stack_bank #(.DATA_W(DATA_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .sel     (sel),
        .wr_data (cr_wr_data),
        .sp_q    (sp_q),
        .int_slot(int_slot),
        .usr_slot(usr_slot),
        .sp_we   (sp_we),
        .sp_d    (sp_d)
    );

    // Backup program counters, stored in full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bkpc   <= '0;
            bkbkpc <= '0;
        end else begin
            if (sel.bkpc)   bkpc   <= cr_wr_data;
            if (sel.bkbkpc) bkbkpc <= cr_wr_data;
        end
    end

    // Spare storage slots
    for (genvar k = 0; k < NUM_SPARE; k++) begin : g_spare
        always_ff @(posedge clk) begin
            if (!rst_n)
                spare[k] <= '0;
            else if (spare_sel[k])
                spare[k] <= cr_wr_data;
        end
    end

    cr_read_mux #(
        .DATA_W    (DATA_W),
        .SPARE_BASE(SPARE_BASE),
        .NUM_SPARE (NUM_SPARE)
    ) u_rd (
        .rd_idx  (cr_rd_idx),
        .mode    (mode),
        .live_st (live_st),
        .bk_st   (bk_st),
        .bkbk_st (bkbk_st),
        .cond    (cond),
        .sp_q    (sp_q),
        .int_slot(int_slot),
        .usr_slot(usr_slot),
        .bkpc    (bkpc),
        .bkbkpc  (bkbkpc),
        .spare   (spare),
        .rd_data (cr_rd_data)
    );

    assign st_rd_data = {live_st[7:1], cond};
endmodule

// File: rtl/banked_cr_file_chk.sv
// Checker: port-level properties of the banked control register file,
// attached to every instance of the top through bind.
module banked_cr_file_chk #(
    parameter int SPARE_BASE = 4,
    parameter int NUM_SPARE  = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cr_wr_en,
    input logic [3:0]  cr_wr_idx,
    input logic [31:0] cr_wr_data,
    input logic [3:0]  cr_rd_idx,
    input logic [31:0] cr_rd_data,
    input logic        st_wr_en,
    input logic [7:0]  st_rd_data,
    input logic        sp_we
);
    logic rd_mapped;
    always_comb begin
        rd_mapped = (cr_rd_idx == 4'd0) || (cr_rd_idx == 4'd1) ||
                    (cr_rd_idx == 4'd2) || (cr_rd_idx == 4'd3) ||
                    (cr_rd_idx == 4'd6) || (cr_rd_idx == 4'd8) ||
                    (cr_rd_idx == 4'd14);
        for (int k = 0; k < NUM_SPARE; k++)
            if (cr_rd_idx == 4'(SPARE_BASE + k)) rd_mapped = 1'b1;
    end

    AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rd_idx == 4'd0) |-> (cr_rd_data[31:16] == 16'h0 && cr_rd_data[5:1] == 5'h0)); // R2
    AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en && cr_wr_idx == 4'd0) |=> (st_rd_data == $past(cr_wr_data[7:0]))); // R3
    AST_MODE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en && cr_wr_idx == 4'd0 && cr_wr_data[7] != st_rd_data[7]) |-> sp_we); // R4
    AST_COND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en && cr_wr_idx == 4'd1) |=> (st_rd_data[0] == $past(cr_wr_data[0]) &&
                                            st_rd_data[7:1] == $past(st_rd_data[7:1]))); // R6
    AST_BKPC_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rd_idx == 4'd6 || cr_rd_idx == 4'd14) |-> !cr_rd_data[0]); // R7
    AST_BKBKST_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rd_idx == 4'd8) |-> ((cr_rd_data & ~32'hC1) == 32'h0)); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mapped |-> (cr_rd_data == 32'h0)); // R10
    AST_BYTE_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && !cr_wr_en) |-> !sp_we); // R11
endmodule

bind banked_cr_file banked_cr_file_chk #(
    .SPARE_BASE(SPARE_BASE),
    .NUM_SPARE (NUM_SPARE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cr_wr_en  (cr_wr_en),
    .cr_wr_idx (cr_wr_idx),
    .cr_wr_data(cr_wr_data),
    .cr_rd_idx (cr_rd_idx),
    .cr_rd_data(cr_rd_data),
    .st_wr_en  (st_wr_en),
    .st_rd_data(st_rd_data),
    .sp_we     (sp_we)
);

// File: tb/test_banked_cr_file.sv
// Directed bench: one task per scenario, each starting from reset.
// Register 15 of the general file is modelled as a plain register.
module test_banked_cr_file;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr_wr_en = 1'b0;
    logic [3:0]  cr_wr_idx = '0;
    logic [31:0] cr_wr_data = '0;
    logic [3:0]  cr_rd_idx = '0;
    logic [31:0] cr_rd_data;
    logic        st_wr_en = 1'b0;
    logic [7:0]  st_wr_data = '0;
    logic [7:0]  st_rd_data;
    logic [31:0] gr15;
    logic        sp_we;
    logic [31:0] sp_d;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // General register 15 model
    always_ff @(posedge clk) begin
        if (!rst_n)     gr15 <= '0;
        else if (sp_we) gr15 <= sp_d;
    end

    banked_cr_file i_banked_cr_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .cr_wr_en  (cr_wr_en),
        .cr_wr_idx (cr_wr_idx),
        .cr_wr_data(cr_wr_data),
        .cr_rd_idx (cr_rd_idx),
        .cr_rd_data(cr_rd_data),
        .st_wr_en  (st_wr_en),
        .st_wr_data(st_wr_data),
        .st_rd_data(st_rd_data),
        .sp_q      (gr15),
        .sp_we     (sp_we),
        .sp_d      (sp_d)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cr_wr_en = 1'b0;
        st_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cr_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        cr_wr_en = 1'b1; cr_wr_idx = idx; cr_wr_data = d;
        @(negedge clk);
        cr_wr_en = 1'b0;
    endtask

    task automatic st_write(input logic [7:0] d);
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_data = d;
        @(negedge clk);
        st_wr_en = 1'b0;
    endtask

    task automatic check_rd(input string req, input logic [3:0] idx, input logic [31:0] exp);
        cr_rd_idx = idx;
        #1;
        check(req, cr_rd_data, exp);
    endtask

    task automatic t_reset();
        do_reset();
        for (int i = 0; i < 16; i++) check_rd("R1", 4'(i), 32'h0);
        check("R1 status port", {24'h0, st_rd_data}, 32'h0);
    endtask

    task automatic t_status_word();
        do_reset();
        cr_write(4'd0, 32'h1234_FF41);
        check_rd("R2", 4'd0, 32'h0000_C141);
        check("R3 byte view", {24'h0, st_rd_data}, 32'h41);
        check_rd("R8 untouched", 4'd8, 32'h0);
        cr_write(4'd0, 32'h0000_3E3E);
        check_rd("R2 masked", 4'd0, 32'h0000_0000);
        check("R3 cond clear", {24'h0, st_rd_data}, 32'h3E);
    endtask

    task automatic t_cond();
        do_reset();
        cr_write(4'd0, 32'h0000_0041);
        cr_write(4'd1, 32'hFFFF_FFFE);
        check_rd("R6 read", 4'd1, 32'h0);
        check("R6 byte", {24'h0, st_rd_data}, 32'h40);
        cr_write(4'd1, 32'h0000_0003);
        check_rd("R6 set", 4'd1, 32'h1);
        check_rd("R6 status", 4'd0, 32'h41);
    endtask

    task automatic t_stack();
        do_reset();
        cr_write(4'd2, 32'hAAAA_0000);
        check("R5 int to gr15", gr15, 32'hAAAA_0000);
        check_rd("R5 int rd", 4'd2, 32'hAAAA_0000);
        cr_write(4'd3, 32'h5555_0000);
        check("R5 usr to slot", gr15, 32'hAAAA_0000);
        check_rd("R5 usr rd", 4'd3, 32'h5555_0000);
        cr_write(4'd0, 32'h0000_0080);
        check("R4 0to1 gr15", gr15, 32'h5555_0000);
        check_rd("R4 int slot", 4'd2, 32'hAAAA_0000);
        check_rd("R5 usr redir", 4'd3, 32'h5555_0000);
        cr_write(4'd3, 32'h1111_0000);
        check("R5 usr to gr15", gr15, 32'h1111_0000);
        cr_write(4'd2, 32'h2222_0000);
        check("R5 int to slot", gr15, 32'h1111_0000);
        cr_write(4'd0, 32'h0000_0081);
        check("R4 same mode", gr15, 32'h1111_0000);
        cr_write(4'd0, 32'h0000_0000);
        check("R4 1to0 gr15", gr15, 32'h2222_0000);
        check_rd("R4 usr slot", 4'd3, 32'h1111_0000);
        check_rd("R5 int redir", 4'd2, 32'h2222_0000);
    endtask

    task automatic t_backups();
        do_reset();
        cr_write(4'd6, 32'hDEAD_BEEF);
        cr_write(4'd14, 32'h1234_5671);
        cr_write(4'd8, 32'hFFFF_FFFF);
        check_rd("R7 bkpc", 4'd6, 32'hDEAD_BEEE);
        check_rd("R7 bkbkpc", 4'd14, 32'h1234_5670);
        check_rd("R8", 4'd8, 32'h0000_00C1);
        cr_write(4'd8, 32'h0000_0040);
        check_rd("R8 partial", 4'd8, 32'h0000_0040);
    endtask

    task automatic t_spare_unmapped();
        do_reset();
        cr_write(4'd4, 32'hCAFE_F00D);
        cr_write(4'd5, 32'h0BAD_0001);
        check_rd("R9 slot4", 4'd4, 32'hCAFE_F00D);
        check_rd("R9 slot5", 4'd5, 32'h0BAD_0001);
        cr_write(4'd7, 32'hFFFF_FFFF);
        cr_write(4'd15, 32'hFFFF_FFFF);
        cr_write(4'd9, 32'hFFFF_FFFF);
        check_rd("R10 rd7", 4'd7, 32'h0);
        check_rd("R10 rd15", 4'd15, 32'h0);
        check_rd("R10 slot4", 4'd4, 32'hCAFE_F00D);
        check_rd("R10 slot5", 4'd5, 32'h0BAD_0001);
        check_rd("R10 status", 4'd0, 32'h0);
        check_rd("R10 bkpc", 4'd6, 32'h0);
        check("R10 gr15", gr15, 32'h0);
    endtask

    task automatic t_status_port();
        do_reset();
        cr_write(4'd2, 32'h0000_7777);
        st_write(8'hFE);
        check("R11 rd", {24'h0, st_rd_data}, 32'hFE);
        st_write(8'h83);
        check("R11 rd2", {24'h0, st_rd_data}, 32'h83);
        check_rd("R11 status", 4'd0, 32'h81);
        check("R11 no swap", gr15, 32'h0000_7777);
        check_rd("R11 int slot", 4'd2, 32'h0);
    endtask

    task automatic t_priority();
        do_reset();
        @(negedge clk);
        cr_wr_en = 1'b1; cr_wr_idx = 4'd1; cr_wr_data = 32'h0;
        st_wr_en = 1'b1; st_wr_data = 8'h41;
        @(negedge clk);
        cr_wr_en = 1'b0; st_wr_en = 1'b0;
        check("R12 cond", {24'h0, st_rd_data}, 32'h0);
        @(negedge clk);
        cr_wr_en = 1'b1; cr_wr_idx = 4'd0; cr_wr_data = 32'h0000_0001;
        st_wr_en = 1'b1; st_wr_data = 8'hC0;
        @(negedge clk);
        cr_wr_en = 1'b0; st_wr_en = 1'b0;
        check("R12 status", {24'h0, st_rd_data}, 32'h01);
        check("R12 gr15", gr15, 32'h0);
    endtask

    initial begin
        t_reset();
        t_status_word();
        t_cond();
        t_stack();
        t_backups();
        t_spare_unmapped();
        t_status_port();
        t_priority();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule